// File: doc/BRIEF.md
# Prescaled Up-Counting Interval Timer

This block is a bus-attached interval timer. A programmable divider turns the input clock into counting ticks. A counter advances on each tick while the run bit is set. A reload register sets the period. When the counter arrives at the reload value, an update event is raised. If both the run bit and the interrupt-enable bit are set, the event latches a sticky status flag and produces a one-cycle interrupt pulse.

Software drives the block through a simple register port. The port has a select and a write strobe, a byte address and 32-bit write data. Read data is combinational. Software can load the counter directly, or zero it with an event strobe. A status bit is cleared by writing a zero to it. A small bank of spare words provides plain read/write storage.

The register layout is as follows. Addresses are byte offsets and must be word aligned.

| Offset | Register | Contents |
|---|---|---|
| 0x00 | control | run bit in bit 0 |
| 0x04 | interrupt enable | enable bit in bit 0 |
| 0x08 | status | update flag in bit 0 |
| 0x0C | event strobe | update-generate request in bit 0 |
| 0x10 | counter | counter value |
| 0x14 | divider | prescaler value |
| 0x18 | reload | reload value |
| 0x20 to 0x2C | spare | four words of plain storage |

Top module: `upcount_timer`

## Requirements
- R1: While the run bit (control, offset 0x00, bit 0) is 1, the counter (offset 0x10, 16 bits) advances by one every (P+1) clock edges, where P is the divider register value. While the run bit is 0, the counter holds its value.
- R2: The divider register (offset 0x14) keeps only the low 16 bits of a write. It reads back with bits 31:16 equal to zero.
- R3: The update event occurs on the tick on which the counter becomes equal to the reload value (offset 0x18).
  - When the event occurs with both the run bit and the interrupt-enable bit (offset 0x04, bit 0) set, the status flag (offset 0x08, bit 0) becomes 1 and `irq` is high for exactly one cycle.
  - When the interrupt-enable bit is 0, neither the flag nor `irq` changes.
- R4: A reload value of zero produces no update event: the flag stays at 0 and `irq` stays low, while the counter keeps counting.
- R5: A write to the status register sets the flag to the old flag AND write-data bit 0. Writing 1 keeps the flag, and writing 0 clears it. A flag set in the same cycle as the write takes priority.
- R6: A write to the event strobe (offset 0x0C) with bit 0 set zeroes the counter. The strobe register always reads 0.
- R7: A write to the counter register loads write-data bits 15:0 into the counter.
- R8: A write to the divider leaves the counter value unchanged.
- R9: After reset, every register reads zero and `irq` is low.
- R10: A read from an unmapped or unaligned address returns zero. A write to such an address changes no register.
- R11: The spare words at offsets 0x20, 0x24, 0x28 and 0x2C store and return all 32 bits of a write.
- R12: The counter wraps to zero on the first tick after the update event. A counter write or an update-generate also clears the divider phase, so the next tick comes a full (P+1) edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | One-cycle update interrupt pulse |

## Verification
Counting is exercised with divider values 0, 2 and 3 over run windows of an exact number of edges. This separates a correct division ratio from an off-by-one in the divider. The event path is run three ways: with interrupts enabled, with interrupts disabled, and with a zero reload. These runs show whether the flag and pulse depend on both enables and on a nonzero period, and the final counter value after the event shows the wrap to zero. A run that starts just after a counter write, with the divider mid-phase, distinguishes a cleared divider phase from a stale one.

// File: rtl/upt_pkg.sv
package upt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PSC_W  = 16;

  // word indices (byte address >> 2)
  localparam logic [ADDR_W-3:0] W_CTRL   = 6'd0;
  localparam logic [ADDR_W-3:0] W_IEN    = 6'd1;
  localparam logic [ADDR_W-3:0] W_STAT   = 6'd2;
  localparam logic [ADDR_W-3:0] W_EVGEN  = 6'd3;
  localparam logic [ADDR_W-3:0] W_CNT    = 6'd4;
  localparam logic [ADDR_W-3:0] W_DIV    = 6'd5;
  localparam logic [ADDR_W-3:0] W_RELOAD = 6'd6;
  localparam logic [ADDR_W-3:0] W_SPARE0 = 6'd8;

  // divider phase step: wraps to zero once the phase reaches the limit
  function automatic logic [PSC_W-1:0] div_step(input logic [PSC_W-1:0] ph,
                                                input logic [PSC_W-1:0] lim);
    return (ph >= lim) ? '0 : ph + 1'b1;
  endfunction

  // counter step with reload wrap; zero reload means free running
  function automatic logic [15:0] cnt_step(input logic [15:0] c,
                                           input logic [15:0] rl);
    return (rl != 0 && c == rl) ? 16'd0 : c + 16'd1;
  endfunction
endpackage

// File: rtl/upt_prescaler.sv
module upt_prescaler
  import upt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  assign tick = run && !clr && (phase_q >= psc);

  always_ff @(posedge clk) begin
    if (!rst_n)   phase_q <= '0;
    else if (clr) phase_q <= '0;
    else if (run) phase_q <= div_step(phase_q, psc);
  end

  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(phase_q));
  p_phase_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == '0));
endmodule

// File: rtl/upt_counter.sv
module upt_counter
  import upt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             upd_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_step(cnt_q, reload);
  assign upd_evt = tick && !load && (reload != '0) && (cnt_nxt == reload);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_nxt;
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && reload != '0 && cnt_q == reload) |=> (cnt_q == '0));
endmodule

// File: rtl/upt_regfile.sv
module upt_regfile
  import upt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SPARE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag_set,
  output logic              run,
  output logic              ien,
  output logic [PSC_W-1:0]  psc,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              flag
);
  localparam int WI_W = ADDR_W - 2;

  logic            aligned;
  logic [WI_W-1:0] widx;
  logic            wr_en;
  logic            run_q, ien_q, flag_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] reload_q;
  logic [DATA_W-1:0] spare_q [SPARE_N];

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_en   = bus_sel && bus_wr && aligned;

  assign cnt_load     = wr_en && ((widx == W_CNT) || (widx == W_EVGEN && bus_wdata[0]));
  assign cnt_load_val = (widx == W_CNT) ? bus_wdata[CNT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
      psc_q    <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      case (widx)
        W_CTRL:   run_q    <= bus_wdata[0];
        W_IEN:    ien_q    <= bus_wdata[0];
        W_DIV:    psc_q    <= bus_wdata[PSC_W-1:0];
        W_RELOAD: reload_q <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (flag_set)                  flag_q <= 1'b1;
    else if (wr_en && widx == W_STAT)   flag_q <= flag_q & bus_wdata[0];
  end

  for (genvar g = 0; g < SPARE_N; g++) begin : g_spare
    localparam logic [WI_W-1:0] IDX = W_SPARE0 + WI_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                     spare_q[g] <= '0;
      else if (wr_en && widx == IDX)  spare_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        W_CTRL:   bus_rdata[0] = run_q;
        W_IEN:    bus_rdata[0] = ien_q;
        W_STAT:   bus_rdata[0] = flag_q;
        W_CNT:    bus_rdata[CNT_W-1:0] = cnt;
        W_DIV:    bus_rdata[PSC_W-1:0] = psc_q;
        W_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
        default: begin
          for (int k = 0; k < SPARE_N; k++)
            if (widx == W_SPARE0 + WI_W'(k)) bus_rdata = spare_q[k];
        end
      endcase
    end
  end

  assign run    = run_q;
  assign ien    = ien_q;
  assign psc    = psc_q;
  assign reload = reload_q;
  assign flag   = flag_q;

  p_flag_andwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_STAT && !bus_wdata[0] && !flag_set) |=> !flag_q);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && widx == W_STAT)) |=> flag_q);
  p_div_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[31:16] == 16'd0) || !(aligned && widx == W_DIV));
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
  import upt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SPARE_N = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic             run, ien, flag, tick, upd_evt, flag_set, cnt_load;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] reload, cnt, cnt_load_val;
  logic             irq_q;

  upt_regfile #(.CNT_W(CNT_W), .SPARE_N(SPARE_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .flag_set(flag_set), .run(run), .ien(ien), .psc(psc),
    .reload(reload), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .flag(flag)
  );

  upt_prescaler u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(cnt_load), .psc(psc), .tick(tick)
  );

  upt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(cnt_load_val), .reload(reload), .cnt(cnt), .upd_evt(upd_evt)
  );

  assign flag_set = upd_evt && run && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= flag_set;
  end
  assign irq = irq_q;

  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run && ien));
  p_irq_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  p_no_evt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(reload) != '0));
  p_ug_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h0C && bus_wdata[0]) |=> (cnt == '0));
  p_cnt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h10) |=> (cnt == $past(bus_wdata[CNT_W-1:0])));
  p_div_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h14 && !run) |=> $stable(cnt));
endmodule

// File: tb/sim_upcount_timer.sv
module sim_upcount_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0, n_irq = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  upcount_timer u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always @(negedge clk) if (irq) n_irq++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_addr = a; #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  // run bit active for exactly n clock edges (n >= 2)
  task automatic run_for(int n);
    wr(8'h00, 1);
    repeat (n - 2) @(negedge clk);
    wr(8'h00, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 12; a++) begin
      rd(8'(a * 4), v);
      check("R9 reset reg", v, 0);
    end
    check("R9 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_count(int p, int n);
    logic [31:0] v;
    wr(8'h14, p); wr(8'h10, 0);
    run_for(n);
    rd(8'h10, v);
    check("R1 count ratio", v, n / (p + 1));
    repeat (5) @(negedge clk);
    rd(8'h10, v);
    check("R1 hold when stopped", v, n / (p + 1));
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h14, 32'h1234_0005); rd(8'h14, v);
    check("R2 divider width", v, 32'h0005);
    wr(8'h10, 32'hABCD_0055); rd(8'h10, v);
    check("R7 counter load", v, 32'h55);
    wr(8'h14, 1); rd(8'h10, v);
    check("R8 divider write keeps count", v, 32'h55);
    wr(8'h10, 32'h40); wr(8'h0C, 1); rd(8'h10, v);
    check("R6 update-generate zeroes", v, 0);
    rd(8'h0C, v);
    check("R6 strobe reads zero", v, 0);
  endtask

  task automatic t_event(bit en, logic [31:0] rl, logic [31:0] exp_cnt, int exp_irq);
    logic [31:0] v;
    wr(8'h08, 0); wr(8'h14, 0); wr(8'h18, rl); wr(8'h04, en); wr(8'h10, 0);
    n_irq = 0;
    run_for(8);
    repeat (2) @(negedge clk);
    rd(8'h10, v);
    check(rl == 0 ? "R4 count with zero reload" : "R12 wrap after event", v, exp_cnt);
    check(rl == 0 ? "R4 no irq" : "R3 irq pulses", n_irq, exp_irq);
    rd(8'h08, v);
    check(rl == 0 ? "R4 no flag" : "R3 flag", v, (exp_irq > 0) ? 1 : 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h08, 1); rd(8'h08, v);
    check("R5 write one keeps flag", v, 1);
    wr(8'h08, 0); rd(8'h08, v);
    check("R5 write zero clears flag", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h10, 32'h77); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h3C, v); check("R10 unmapped reads zero", v, 0);
    rd(8'h11, v); check("R10 unaligned reads zero", v, 0);
    rd(8'h10, v); check("R10 counter untouched", v, 32'h77);
    rd(8'h00, v); check("R10 control untouched", v, 0);
    for (int k = 0; k < 4; k++) wr(8'(32 + 4 * k), 32'hC0DE_0000 + k);
    for (int k = 0; k < 4; k++) begin
      rd(8'(32 + 4 * k), v);
      check("R11 spare word", v, 32'hC0DE_0000 + k);
    end
  endtask

  task automatic t_phase();
    logic [31:0] v;
    wr(8'h18, 0); wr(8'h14, 3); wr(8'h10, 0);
    run_for(6);
    wr(8'h10, 0);
    run_for(3);
    rd(8'h10, v);
    check("R12 divider phase cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count(0, 10);
    t_count(3, 22);
    t_count(2, 9);
    t_regs();
    t_event(1, 5, 2, 1);
    t_clear();
    t_event(0, 5, 2, 0);
    t_event(1, 0, 8, 0);
    t_unmapped();
    t_phase();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule